// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Tracker

This block follows the clock-enable pin of a single-data-rate SDRAM and works out which low-power condition the device is in. On every rising clock edge it registers CKE and the command code. It then decides the next power state from four things: the CKE value seen at the previous edge, the CKE value seen now, the state held before this edge, and the command on the bus now. The states are normal running, power-down, self refresh, a self-refresh exit wait, and clock suspend.

A memory-controller model or a device model uses it to gate its command logic. When `cmd_accept` is high, the normal command path may act on the next edge. A status input tells the block whether a read or write burst is in progress or all banks are idle. Any combination of CKE, state and command that the rules below do not allow raises a sticky error flag. The power state stays where it was on such an edge.

When the device leaves self refresh, it stays unavailable for `TXSR_CYC` edges. Every one of those edges must carry a quiet command, and at least `MIN_NOPS` of them must be true NOPs.

Top module: `cke_power_tracker`

## Requirements
- R1: During and right after reset, `pwr_state` is 0 (running), `cmd_accept` is 1 and `illegal_err` is 0. The remembered previous CKE is high.
- R2: Commands use the code {cs_n, ras_n, cas_n, we_n}. 1xxx is inhibit, 0111 is NOP, 0001 is auto refresh. "Quiet" means inhibit or NOP. In running state (0), with CKE high at both edges, the state stays 0 and `cmd_accept` stays 1 whatever the command.
- R3: In power-down (1), self refresh (2) or clock suspend (4), CKE low at both edges keeps the state and ignores the command.
- R4: In running state with all banks idle, a high-to-low CKE step behaves as follows. A quiet command enters power-down (1). Auto refresh enters self refresh (2). Any other command is illegal.
- R5: In running state with `burst_active` high, a high-to-low CKE step enters clock suspend (4) whatever the command.
- R6: In power-down, a low-to-high CKE step with a quiet command returns to running state after that edge, with `cmd_accept` high for the next edge.
- R7: In self refresh, a low-to-high CKE step with a quiet command enters the exit wait (3), with `cmd_accept` low.
- R8: The exit wait covers the `TXSR_CYC` edges after the exit edge. If at least two of those edges carried NOP, the state is running after the last one.
- R9: If fewer than two NOPs were seen by the last edge of the wait, `illegal_err` is set and the state stays 3. It moves to running after the edge that brings the NOP count to two.
- R10: In clock suspend, a low-to-high CKE step returns to running state whatever the command.
- R11: These combinations are illegal: a non-quiet command on a power-down or self-refresh exit, a non-quiet command or low CKE during the exit wait, and any combination not listed above. Each one sets `illegal_err`, which stays high until reset, and the state holds.
- R12: `cmd_accept` is high exactly when the state is running (0), and low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 4 | Command code {cs_n, ras_n, cas_n, we_n} |
| burst_active | input | 1 | 1 = read or write burst in progress, 0 = all banks idle |
| pwr_state | output | 3 | 0 running, 1 power-down, 2 self refresh, 3 exit wait, 4 clock suspend |
| cmd_accept | output | 1 | A command may be acted on at the next edge |
| illegal_err | output | 1 | Sticky flag for illegal CKE/state/command combinations |

## Verification
The stimulus drives the same high-to-low CKE step with NOP, inhibit and auto refresh while idle, and with a write while a burst runs. This separates the three entry targets and shows that the burst status overrides the command. Each low-power state sees low-low CKE with commands that would normally act, which shows the commands are ignored. It then sees a low-to-high step with a quiet command and with an active one, which separates legal exits from illegal ones. The self-refresh exit is run once with NOPs at the ends of the wait and once with only inhibits, so the expiry check, the error and the extended wait each show at the ports.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

   localparam int CMD_W = 4;

   typedef enum logic [2:0] {
      PS_RUN  = 3'd0,
      PS_PDN  = 3'd1,
      PS_SREF = 3'd2,
      PS_SRX  = 3'd3,
      PS_SUSP = 3'd4
   } pwr_state_e;

   localparam logic [CMD_W-1:0] CMD_NOP  = 4'b0111;
   localparam logic [CMD_W-1:0] CMD_AREF = 4'b0001;

   typedef struct packed {
      logic quiet;
      logic nop;
      logic aref;
   } cmd_kind_t;

endpackage

// File: rtl/cke_hist_reg.sv
module cke_hist_reg #(
   parameter logic RESET_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cke_now,
   output logic cke_last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_last <= RESET_LVL;
      else        cke_last <= cke_now;
   end
endmodule

// File: rtl/cmd_sorter.sv
module cmd_sorter
   import cke_pwr_pkg::*;
#(
   parameter bit INHIBIT_IS_QUIET = 1'b1
) (
   input  logic [CMD_W-1:0] cmd,
   output cmd_kind_t        kind
);
   logic inhibit;
   assign inhibit   = cmd[CMD_W-1];
   assign kind.nop  = (cmd == CMD_NOP);
   assign kind.aref = (cmd == CMD_AREF);

   generate
      if (INHIBIT_IS_QUIET) begin : g_inh_quiet
         assign kind.quiet = inhibit | kind.nop;
      end else begin : g_nop_only
         assign kind.quiet = kind.nop;
      end
   endgenerate
endmodule

// File: rtl/srx_wait_timer.sv
module srx_wait_timer #(
   parameter int TXSR_CYC = 8,
   parameter int MIN_NOPS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   input  logic is_nop,
   output logic final_edge,
   output logic expiring,
   output logic nops_ok
);
   localparam int CW = $clog2(TXSR_CYC + 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       remain <= '0;
      else if (start)                   remain <= CW'(TXSR_CYC);
      else if (tick && remain != '0)    remain <= remain - CW'(1);
   end

   assign final_edge = (remain <= CW'(1));
   assign expiring   = (remain == CW'(1));

   generate
      if (MIN_NOPS > 0) begin : g_nop_cnt
         localparam int NW = $clog2(MIN_NOPS + 1);
         logic [NW-1:0] seen;
         logic [NW:0]   seen_now;

         assign seen_now = {1'b0, seen} + (NW+1)'(is_nop);
         assign nops_ok  = (seen_now >= (NW+1)'(MIN_NOPS));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       seen <= '0;
            else if (start)                                   seen <= '0;
            else if (tick && is_nop && seen != NW'(MIN_NOPS)) seen <= seen + NW'(1);
         end
      end else begin : g_no_nop
         logic unused_nop;
         assign unused_nop = is_nop;
         assign nops_ok    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
   import cke_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke_last,
   input  logic       cke_now,
   input  cmd_kind_t  kind,
   input  logic       burst_active,
   input  logic       final_edge,
   input  logic       expiring,
   input  logic       nops_ok,
   output logic       srx_start,
   output logic       srx_tick,
   output pwr_state_e state,
   output logic       err
);
   pwr_state_e nxt;
   logic       bad;
   logic       stay_low, rise, fall, stay_high;

   assign stay_low  = !cke_last && !cke_now;
   assign rise      = !cke_last &&  cke_now;
   assign fall      =  cke_last && !cke_now;
   assign stay_high =  cke_last &&  cke_now;

   always_comb begin
      nxt       = state;
      bad       = 1'b0;
      srx_start = 1'b0;
      srx_tick  = 1'b0;
      unique case (state)
         PS_RUN: begin
            if (fall) begin
               if (burst_active)    nxt = PS_SUSP;
               else if (kind.quiet) nxt = PS_PDN;
               else if (kind.aref)  nxt = PS_SREF;
               else                 bad = 1'b1;
            end else if (!stay_high) begin
               bad = 1'b1;
            end
         end
         PS_PDN: begin
            if (rise && kind.quiet) nxt = PS_RUN;
            else if (!stay_low)     bad = 1'b1;
         end
         PS_SREF: begin
            if (rise && kind.quiet) begin
               nxt       = PS_SRX;
               srx_start = 1'b1;
            end else if (!stay_low) begin
               bad = 1'b1;
            end
         end
         PS_SUSP: begin
            if (rise)           nxt = PS_RUN;
            else if (!stay_low) bad = 1'b1;
         end
         PS_SRX: begin
            srx_tick = 1'b1;
            if (!stay_high || !kind.quiet) begin
               bad = 1'b1;
            end else begin
               if (final_edge && nops_ok) nxt = PS_RUN;
               if (expiring && !nops_ok)  bad = 1'b1;
            end
         end
         default: begin
            nxt = PS_RUN;
            bad = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_RUN;
         err   <= 1'b0;
      end else begin
         if (!bad) state <= nxt;
         if (bad)  err   <= 1'b1;
      end
   end
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
   import cke_pwr_pkg::*;
#(
   parameter int TXSR_CYC = 8,
   parameter int MIN_NOPS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic [CMD_W-1:0] cmd,
   input  logic             burst_active,
   output logic [2:0]       pwr_state,
   output logic             cmd_accept,
   output logic             illegal_err
);
   generate
      if (TXSR_CYC < 1) begin : g_bad_txsr
         $error("TXSR_CYC must be at least 1");
      end
      if (MIN_NOPS < 0 || MIN_NOPS > TXSR_CYC) begin : g_bad_nops
         $error("MIN_NOPS must lie between 0 and TXSR_CYC");
      end
   endgenerate

   logic       cke_last;
   cmd_kind_t  kind;
   logic       srx_start, srx_tick;
   logic       final_edge, expiring, nops_ok;
   pwr_state_e state;

   cke_hist_reg #(.RESET_LVL(1'b1)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke_now  (cke),
      .cke_last (cke_last)
   );

   cmd_sorter #(.INHIBIT_IS_QUIET(1'b1)) u_sort (
      .cmd  (cmd),
      .kind (kind)
   );

   srx_wait_timer #(.TXSR_CYC(TXSR_CYC), .MIN_NOPS(MIN_NOPS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (srx_start),
      .tick       (srx_tick),
      .is_nop     (kind.nop),
      .final_edge (final_edge),
      .expiring   (expiring),
      .nops_ok    (nops_ok)
   );

   cke_state_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cke_last     (cke_last),
      .cke_now      (cke),
      .kind         (kind),
      .burst_active (burst_active),
      .final_edge   (final_edge),
      .expiring     (expiring),
      .nops_ok      (nops_ok),
      .srx_start    (srx_start),
      .srx_tick     (srx_tick),
      .state        (state),
      .err          (illegal_err)
   );

   assign pwr_state  = state;
   assign cmd_accept = (state == PS_RUN);
endmodule

// File: rtl/cke_power_tracker_chk.sv
module cke_power_tracker_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic [3:0] cmd,
   input logic       burst_active,
   input logic [2:0] pwr_state,
   input logic       cmd_accept,
   input logic       illegal_err
);
   logic cke_d;
   logic quiet, aref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_d <= 1'b1;
      else        cke_d <= cke;
   end

   assign quiet = cmd[3] || (cmd == 4'b0111);
   assign aref  = (cmd == 4'b0001);

   // R3
   low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_d && !cke && (pwr_state == 3'd1 || pwr_state == 3'd2 || pwr_state == 3'd4))
      |=> $stable(pwr_state));

   // R4
   pdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd0 && cke_d && !cke && !burst_active && quiet) |=> pwr_state == 3'd1);

   // R4
   sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd0 && cke_d && !cke && !burst_active && aref) |=> pwr_state == 3'd2);

   // R5
   susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd0 && cke_d && !cke && burst_active) |=> pwr_state == 3'd4);

   // R6
   pdn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd1 && !cke_d && cke && quiet) |=> (pwr_state == 3'd0 && cmd_accept));

   // R7
   sref_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd2 && !cke_d && cke && quiet) |=> (pwr_state == 3'd3 && !cmd_accept));

   // R10
   susp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd4 && !cke_d && cke) |=> pwr_state == 3'd0);

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_err |=> illegal_err);

   // R12
   accept_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != 3'd0) |-> !cmd_accept);
endmodule

bind cke_power_tracker cke_power_tracker_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cke          (cke),
   .cmd          (cmd),
   .burst_active (burst_active),
   .pwr_state    (pwr_state),
   .cmd_accept   (cmd_accept),
   .illegal_err  (illegal_err)
);

// File: tb/cke_power_tracker_bench.sv
`timescale 1ns/1ps
module cke_power_tracker_bench;
   localparam int TXSR = 8;

   localparam logic [3:0] NOP  = 4'b0111;
   localparam logic [3:0] INH  = 4'b1111;
   localparam logic [3:0] AREF = 4'b0001;
   localparam logic [3:0] ACT  = 4'b0011;
   localparam logic [3:0] RD   = 4'b0101;
   localparam logic [3:0] WR   = 4'b0100;

   localparam logic [2:0] S_RUN = 3'd0, S_PDN = 3'd1, S_SREF = 3'd2, S_SRX = 3'd3, S_SUSP = 3'd4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic [3:0] cmd = NOP;
   logic       burst = 1'b0;
   logic [2:0] pwr_state;
   logic       cmd_accept;
   logic       illegal_err;

   int checks = 0;
   int errors = 0;

   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   cke_power_tracker #(.TXSR_CYC(TXSR), .MIN_NOPS(2)) u_cke_power_tracker (
      .clk          (clk),
      .rst_n        (rst_n),
      .cke          (cke),
      .cmd          (cmd),
      .burst_active (burst),
      .pwr_state    (pwr_state),
      .cmd_accept   (cmd_accept),
      .illegal_err  (illegal_err)
   );

   task automatic compare(input string tag, input logic [4:0] expv);
      logic [4:0] act;
      act = {pwr_state, cmd_accept, illegal_err};
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: state/accept/err actual %0d/%0d/%0d expected %0d/%0d/%0d",
                  tag, act[4:2], act[1], act[0], expv[4:2], expv[1], expv[0]);
      end
   endtask

   // monitor: pops one expectation per falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [4:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         compare(t, e);
      end
   end

   // driver: applies one edge of stimulus and queues what must follow it
   task automatic step(input logic c, input logic [3:0] k, input logic b,
                       input logic [2:0] es, input logic ea, input logic ee, input string tag);
      @(negedge clk);
      #1;
      cke   = c;
      cmd   = k;
      burst = b;
      @(posedge clk);
      #1;
      exp_q.push_back({es, ea, ee});
      tag_q.push_back(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      @(negedge clk);
      #2;
      rst_n = 1'b0;
      cke   = 1'b1;
      cmd   = NOP;
      burst = 1'b0;
      @(negedge clk);
      compare("R1 during reset", {S_RUN, 1'b1, 1'b0});
      #2;
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset", {S_RUN, 1'b1, 1'b0});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();

      // R2: high-high passes commands through
      step(1, ACT, 0, S_RUN, 1, 0, "R2 act");
      step(1, RD,  1, S_RUN, 1, 0, "R2 read");
      step(1, INH, 0, S_RUN, 1, 0, "R2 inhibit");

      // R4 / R3 / R6: power-down with NOP, ignored commands, exit
      step(0, NOP,  0, S_PDN, 0, 0, "R4 nop to pdn");
      step(0, RD,   0, S_PDN, 0, 0, "R3 pdn ignores read");
      step(0, AREF, 0, S_PDN, 0, 0, "R3 pdn ignores aref");
      step(1, NOP,  0, S_RUN, 1, 0, "R6 pdn exit");
      step(1, ACT,  0, S_RUN, 1, 0, "R6 command after exit");

      // R4: inhibit also enters power-down
      step(0, INH, 0, S_PDN, 0, 0, "R4 inhibit to pdn");
      step(1, INH, 0, S_RUN, 1, 0, "R6 pdn exit inhibit");

      // R4 / R3 / R7 / R8: self refresh and a well-formed exit wait
      step(0, AREF,   0, S_SREF, 0, 0, "R4 aref to sref");
      step(0, 4'b0000, 0, S_SREF, 0, 0, "R3 sref ignores cmd");
      step(1, INH,    0, S_SRX,  0, 0, "R7 sref exit");
      for (int i = 1; i <= TXSR; i++) begin
         step(1, (i == 1 || i == TXSR) ? NOP : INH, 0,
              (i < TXSR) ? S_SRX : S_RUN, (i == TXSR), 0, "R8 exit wait");
      end

      // R5 / R3 / R10: clock suspend during a burst
      step(1, RD,  1, S_RUN,  1, 0, "R2 read");
      step(0, WR,  1, S_SUSP, 0, 0, "R5 suspend entry");
      step(0, ACT, 1, S_SUSP, 0, 0, "R3 suspend ignores act");
      step(1, ACT, 1, S_RUN,  1, 0, "R10 suspend exit");
      step(1, NOP, 0, S_RUN,  1, 0, "R12 accept in run");

      // R9: exit wait with no NOPs
      do_reset();
      step(0, AREF, 0, S_SREF, 0, 0, "R4 aref to sref");
      step(1, NOP,  0, S_SRX,  0, 0, "R7 sref exit");
      for (int i = 1; i <= TXSR; i++) begin
         step(1, INH, 0, S_SRX, 0, (i == TXSR), "R9 no nops");
      end
      step(1, NOP, 0, S_SRX, 0, 1, "R9 first late nop");
      step(1, NOP, 0, S_RUN, 1, 1, "R9 second late nop");
      step(1, ACT, 0, S_RUN, 1, 1, "R11 err sticky");

      // R11: active command on power-down exit
      do_reset();
      step(0, NOP, 0, S_PDN, 0, 0, "R4 nop to pdn");
      step(1, ACT, 0, S_PDN, 0, 1, "R11 bad pdn exit");
      step(1, NOP, 0, S_PDN, 0, 1, "R11 unlisted high-high in pdn");

      // R11: active command on idle high-to-low
      do_reset();
      step(0, RD, 0, S_RUN, 1, 1, "R11 bad entry cmd");

      // R11: active command during exit wait
      do_reset();
      step(0, AREF, 0, S_SREF, 0, 0, "R4 aref to sref");
      step(1, NOP,  0, S_SRX,  0, 0, "R7 sref exit");
      step(1, RD,   0, S_SRX,  0, 1, "R11 read in exit wait");

      // R11: active command on self-refresh exit
      do_reset();
      step(0, AREF, 0, S_SREF, 0, 0, "R4 aref to sref");
      step(1, ACT,  0, S_SREF, 0, 1, "R11 bad sref exit");

      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule